// File: doc/BRIEF.md
# Vertical Character-Row Scaler

This block produces the vertical timing for a character overlay. It counts active horizontal sync edges from the most recent active vertical sync edge. After a programmable start delay, it reports for every scanline three things: the character row being drawn (0 to 9), the font line to fetch (0 to 17), and a flag that marks the visible band.

A character cell has 18 font lines. It is stretched to a taller height by showing chosen font lines on more than one consecutive scanline, so the height is not produced by a uniform divide. A 7-bit height code sets the stretch:

- The two upper bits add whole-cell repeats.
- The five lower bits add single repeats on fixed, bit-weighted line sets.
- A per-row double-height bit doubles the scanlines spent on every font line of that row.

Each sync input has its own polarity select. The block is fed by sync edge detectors running in the pixel-side clock domain. Its outputs drive the font fetch and the overlay enable.

Top module: `osd_vrow_scaler`

## Requirements
- R1: While reset is asserted, and after it is released until the first display start, vactive_o is 0, row_o is 0 and line_o is 0.
- R2: With a polarity bit at 1 the matching sync input is active on its rising edge; with it at 0 it is active on its falling edge. The opposite edge has no effect.
- R3: With delay code D on vert_delay_i, the first visible scanline (row 0, font line 0, vactive_o=1) appears on the (4*D+1)-th active hsync edge after an active vsync edge. Hsync edges seen before any vsync edge never start the display.
- R4: height_code_i[6:5] = w adds w extra scanlines to every one of the 18 font lines.
- R5: Fine bit 0 adds one scanline to font line 8. Bit 1 adds one to lines 4 and 12. Bit 2 adds one to lines 2, 6, 10 and 14. Bit 3 adds one to the odd lines 1 to 15.
- R6: When height_code_i[4:0] is 16, lines 1 to 16 get one extra scanline each. When height_code_i[4:0] is 17 or more, it is treated as 17, and lines 0 to 16 get one extra scanline each.
- R7: The whole-cell extras and the fine extras add. Font line n is shown on 1 + w + fine(n) consecutive scanlines, so a cell is 18 + min(code[4:0],17) + 18*w scanlines tall.
- R8: When row_dbl_i[r] is 1, every font line of row r takes twice the scanline count that R7 gives.
- R9: Font lines run 0 to 17 within a row, and rows run 0 to 9. On the active hsync edge after the last scanline of row 9, vactive_o falls and row_o and line_o return to 0. They stay there until the next start.
- R10: An active vsync edge clears vactive_o, row_o and line_o at any time, including mid-frame, and restarts the delay count. An hsync edge in the same cycle is not counted.
- R11: Outputs change only in a cycle that sees an active hsync or vsync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync, sampled on clk_i |
| vsync_i | input | 1 | Vertical sync, sampled on clk_i |
| hsync_pol_i | input | 1 | 1: rising edge of hsync_i is active; 0: falling edge |
| vsync_pol_i | input | 1 | 1: rising edge of vsync_i is active; 0: falling edge |
| vert_delay_i | input | 8 | Start delay code D; start at line 4*D+1 |
| height_code_i | input | 7 | [6:5] whole-cell repeats, [4:0] fine repeats |
| row_dbl_i | input | 10 | Double-height enable, one bit per character row |
| row_o | output | 4 | Current character row |
| line_o | output | 5 | Font line to fetch |
| vactive_o | output | 1 | Scanline lies in the visible character band |

## Verification
The delicate overlap is a vertical sync edge that lands in the same clock as a horizontal sync edge. The restart must win, and that hsync edge must neither advance the visible band nor count toward the start delay. The bench provokes this at the start of a frame with delay code 0 and judges it at the next edge. That edge must then be exactly the first visible scanline (row 0, line 0). A counted coincident edge would have started the display one edge early. A mid-frame vsync cut is also driven, and the outputs must drop at once.

// File: rtl/osd_vrow_pkg.sv
package osd_vrow_pkg;
  localparam int unsigned VR_FONT_LINES = 18;  // font lines per character cell
  localparam int unsigned VR_FINE_W     = 5;   // width of the fine repeat field
  localparam int unsigned VR_FINE_SAT   = 17;  // fine field saturation value
  localparam int unsigned VR_SPAN_W     = 4;   // up to (1+3+1)*2 = 10 scanlines
  typedef logic [VR_SPAN_W-1:0] vr_span_t;
endpackage

// File: rtl/osd_vrow_edge.sv
module osd_vrow_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic pol_i,
  output logic edge_o
);
  logic norm, prev_q;

  // normalise to active-high; polarity 1 keeps the level
  assign norm = sig_i ~^ pol_i;

  // reset to "asserted" so a level held through reset gives no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= norm;
  end

  assign edge_o = norm & ~prev_q;

  p_edge_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o)
    else $error("edge detector produced a two-cycle pulse");
endmodule

// File: rtl/osd_vrow_delay.sv
module osd_vrow_delay #(
  parameter int unsigned DELAY_W = 8,
  localparam int unsigned CNT_W  = DELAY_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vs_edge_i,
  input  logic               hs_edge_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               start_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, total;
  logic             armed_q, hit;

  assign total   = {delay_i, 2'b00} + CNT_W'(1);
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = (cnt_inc == total);
  assign start_o = armed_q & hs_edge_i & ~vs_edge_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (vs_edge_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && hs_edge_i) begin
      if (hit) armed_q <= 1'b0;
      else     cnt_q   <= cnt_inc;
    end
  end

  p_arm_on_vsync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_edge_i |=> (armed_q && cnt_q == '0))
    else $error("delay counter not re-armed by vsync");

  p_single_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !armed_q)
    else $error("delay counter still armed after start");
endmodule

// File: rtl/osd_vrow_span.sv
module osd_vrow_span
  import osd_vrow_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned LINE_W = 5
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              dbl_i,
  output vr_span_t          span_o
);
  localparam int unsigned COARSE_W = CODE_W - VR_FINE_W;
  localparam logic [LINE_W-1:0] L_ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_16  = LINE_W'(16);

  logic [VR_FINE_W-1:0] fine;
  logic [COARSE_W-1:0]  coarse;
  logic                 sat;
  logic [VR_FINE_W-1:0] hit;
  logic [2:0]           base;

  assign fine   = code_i[VR_FINE_W-1:0];
  assign coarse = code_i[CODE_W-1:VR_FINE_W];
  assign sat    = (fine >= VR_FINE_W'(VR_FINE_SAT));

  // fine bit k marks lines n < 16 with n mod 2^(4-k) == 2^(3-k)
  for (genvar k = 0; k < 4; k++) begin : g_fine
    localparam logic [LINE_W-1:0] MASK = LINE_W'((1 << (4 - k)) - 1);
    localparam logic [LINE_W-1:0] VAL  = LINE_W'(1 << (3 - k));
    assign hit[k] = ~sat & fine[k] & (line_i < L_16) & ((line_i & MASK) == VAL);
  end

  // top fine bit: lines 1..16, or 0..16 once saturated
  assign hit[4] = sat ? (line_i <= L_16)
                      : (fine[4] & (line_i >= L_ONE) & (line_i <= L_16));

  assign base   = 3'd1 + 3'(coarse) + {2'b00, |hit};
  assign span_o = dbl_i ? {base, 1'b0} : {1'b0, base};
endmodule

// File: rtl/osd_vrow_scaler.sv
module osd_vrow_scaler
  import osd_vrow_pkg::*;
#(
  parameter int unsigned ROWS    = 10,
  parameter int unsigned DELAY_W = 8,
  parameter int unsigned CODE_W  = 7,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned LINE_W = $clog2(VR_FONT_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               hsync_pol_i,
  input  logic               vsync_pol_i,
  input  logic [DELAY_W-1:0] vert_delay_i,
  input  logic [CODE_W-1:0]  height_code_i,
  input  logic [ROWS-1:0]    row_dbl_i,
  output logic [ROW_W-1:0]   row_o,
  output logic [LINE_W-1:0]  line_o,
  output logic               vactive_o
);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(VR_FONT_LINES - 1);

  logic [1:0] sync_in, sync_pol, sync_edge;
  logic       hs_edge, vs_edge, start;
  vr_span_t   span, rep_q, rep_inc;
  logic [ROW_W-1:0]  row_q;
  logic [LINE_W-1:0] line_q;
  logic              act_q;

  assign sync_in  = {vsync_i, hsync_i};
  assign sync_pol = {vsync_pol_i, hsync_pol_i};

  for (genvar s = 0; s < 2; s++) begin : g_sync
    osd_vrow_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sync_in[s]),
      .pol_i  (sync_pol[s]),
      .edge_o (sync_edge[s])
    );
  end

  assign hs_edge = sync_edge[0];
  assign vs_edge = sync_edge[1];

  osd_vrow_delay #(.DELAY_W(DELAY_W)) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vs_edge_i (vs_edge),
    .hs_edge_i (hs_edge),
    .delay_i   (vert_delay_i),
    .start_o   (start)
  );

  osd_vrow_span #(.CODE_W(CODE_W), .LINE_W(LINE_W)) u_span (
    .line_i (line_q),
    .code_i (height_code_i),
    .dbl_i  (row_dbl_i[row_q]),
    .span_o (span)
  );

  assign rep_inc = rep_q + VR_SPAN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      row_q  <= '0;
      line_q <= '0;
      rep_q  <= '0;
    end else if (vs_edge) begin
      act_q  <= 1'b0;
      row_q  <= '0;
      line_q <= '0;
      rep_q  <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      row_q  <= '0;
      line_q <= '0;
      rep_q  <= '0;
    end else if (act_q && hs_edge) begin
      if (rep_inc < span) begin
        rep_q <= rep_inc;
      end else begin
        rep_q <= '0;
        if (line_q == LAST_LINE) begin
          line_q <= '0;
          if (row_q == LAST_ROW) begin
            act_q <= 1'b0;
            row_q <= '0;
          end else begin
            row_q <= row_q + ROW_W'(1);
          end
        end else begin
          line_q <= line_q + LINE_W'(1);
        end
      end
    end
  end

  assign row_o     = row_q;
  assign line_o    = line_q;
  assign vactive_o = act_q;

  p_vsync_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_edge |=> (!vactive_o && row_o == '0 && line_o == '0))
    else $error("vsync did not clear the band");

  p_quiet_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_edge && !vs_edge) |=> ($stable(vactive_o) && $stable(row_o) && $stable(line_o)))
    else $error("outputs moved without a sync edge");

  p_index_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vactive_o |-> (row_o <= LAST_ROW && line_o <= LAST_LINE))
    else $error("row or font line out of range");

  p_line_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vactive_o && hs_edge && !vs_edge) |=>
      (!vactive_o || line_o == $past(line_o) || line_o == $past(line_o) + LINE_W'(1)
       || (line_o == '0 && row_o == $past(row_o) + ROW_W'(1))))
    else $error("font line skipped");

  p_span_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (span >= VR_SPAN_W'(1) && span <= VR_SPAN_W'(10)))
    else $error("span out of range");

  p_rep_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vactive_o |-> (rep_q < span))
    else $error("repeat counter past its span");
endmodule

// File: tb/osd_vrow_scaler_tb.sv
module osd_vrow_scaler_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_act = 1'b0, vs_act = 1'b0;
  logic hpol = 1'b1, vpol = 1'b1;
  logic hsync_i, vsync_i;
  logic [7:0] vert_delay = 8'd4;
  logic [6:0] height_code = '0;
  logic [9:0] row_dbl = '0;
  logic [3:0] row_o;
  logic [4:0] line_o;
  logic       vactive_o;

  int checks = 0;
  int failures = 0;

  typedef struct { bit a; int r; int l; string t; } exp_t;
  exp_t exp_q[$];
  event ev_chk;

  always #2.5 clk = ~clk;

  assign hsync_i = hpol ? hs_act : ~hs_act;
  assign vsync_i = vpol ? vs_act : ~vs_act;

  osd_vrow_scaler dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .hsync_i       (hsync_i),
    .vsync_i       (vsync_i),
    .hsync_pol_i   (hpol),
    .vsync_pol_i   (vpol),
    .vert_delay_i  (vert_delay),
    .height_code_i (height_code),
    .row_dbl_i     (row_dbl),
    .row_o         (row_o),
    .line_o        (line_o),
    .vactive_o     (vactive_o)
  );

  // extra scanlines for font line n, from R4..R7
  function automatic int b_extra(int n, int code);
    int w = code >> 5;
    int f = code & 31;
    int e = w;
    if (f >= 17) begin
      if (n <= 16) e++;
    end else begin
      if ((f & 16) != 0 && n >= 1 && n <= 16) e++;
      if ((f & 8) != 0 && n % 2 == 1 && n < 16) e++;
      if ((f & 4) != 0 && n % 4 == 2) e++;
      if ((f & 2) != 0 && n % 8 == 4) e++;
      if ((f & 1) != 0 && n == 8) e++;
    end
    return e;
  endfunction

  task automatic push(bit a, int r, int l, string t);
    exp_t e;
    e.a = a; e.r = r; e.l = l; e.t = t;
    exp_q.push_back(e);
    -> ev_chk;
  endtask

  // one active hsync edge; check after it and again one cycle after release
  task automatic tick(bit a, int r, int l, string t);
    @(negedge clk); hs_act = 1'b1;
    @(negedge clk); push(a, r, l, t); hs_act = 1'b0;
    @(negedge clk); push(a, r, l, "R11 hold between edges");
  endtask

  task automatic frame(int vd, int code, bit [9:0] dbl, bit coinc, int limit, string t);
    int d, n, span;
    @(negedge clk);
    vert_delay = 8'(vd); height_code = 7'(code); row_dbl = dbl;
    vs_act = 1'b1;
    if (coinc) hs_act = 1'b1;
    @(negedge clk); push(0, 0, 0, "R10 vsync restart"); vs_act = 1'b0; hs_act = 1'b0;
    @(negedge clk); push(0, 0, 0, "R10 hold after vsync");
    d = vd * 4 + 1;
    n = 0;
    for (int k = 1; k < d; k++) begin
      tick(0, 0, 0, "R3 start delay");
      n++;
      if (limit >= 0 && n >= limit) return;
    end
    for (int r = 0; r < 10; r++)
      for (int l = 0; l < 18; l++) begin
        span = (1 + b_extra(l, code)) * (dbl[r] ? 2 : 1);
        for (int s = 0; s < span; s++) begin
          tick(1, r, l, t);
          n++;
          if (limit >= 0 && n >= limit) return;
        end
      end
    tick(0, 0, 0, "R9 band end after row 9");
    tick(0, 0, 0, "R9 stays dark until vsync");
  endtask

  // monitor: pop each expected item and compare
  initial begin
    exp_t e;
    forever begin
      @(ev_chk);
      e = exp_q.pop_front();
      checks++;
      if (vactive_o !== e.a || int'(row_o) != e.r || int'(line_o) != e.l) begin
        failures++;
        $display("FAIL %s: act=%0d row=%0d line=%0d expected act=%0d row=%0d line=%0d",
                 e.t, vactive_o, row_o, line_o, e.a, e.r, e.l);
      end
    end
  end

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (vactive_o !== 1'b0 || row_o !== '0 || line_o !== '0) begin
      failures++;
      $display("FAIL R1 in reset: act=%0d row=%0d line=%0d expected 0/0/0", vactive_o, row_o, line_o);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    push(0, 0, 0, "R1 after reset");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, "R3 no vsync yet");

    frame(4, 7'h00, 10'h000, 0, -1, "R9 plain cell");
    frame(0, 7'h20, 10'h000, 0, -1, "R4 whole repeat");
    frame(1, 7'h0F, 10'h000, 0, -1, "R5 fine pattern");
    frame(0, 7'h10, 10'h000, 0, -1, "R6 top fine bit");
    frame(0, 7'h1F, 10'h000, 0, -1, "R6 saturated fine");
    frame(0, 7'h65, 10'h000, 0, -1, "R7 additive repeats");
    frame(0, 7'h02, 10'h205, 0, -1, "R8 double height");

    @(negedge clk); hpol = 1'b0; vpol = 1'b0;
    frame(2, 7'h03, 10'h000, 0, -1, "R2 negative polarity");
    @(negedge clk); hpol = 1'b1; vpol = 1'b1;

    frame(1, 7'h00, 10'h000, 0, 40, "R10 cut mid-frame");
    frame(0, 7'h01, 10'h000, 1, -1, "R10 coincident edges");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule